// File: doc/BRIEF.md
# Event and Cycle Performance Counter Unit

This block watches a processor's activity through three 32-bit counters. One of them counts clock cycles, either every clock or once per 64 clocks. The other two each count one line chosen from a vector of single-cycle event pulses. The line is picked by an 8-bit event code held in the shared control word.

There is a single global enable, so no counter can be switched on or off on its own. To halt an event counter, software gives it the silent code 0x20. That code selects a line that never pulses.

Each counter raises a sticky overflow flag when an increment carries it from all-ones back to zero. Software clears a flag by writing 1 to it. The flags share the control word with the configuration fields, so writing back a value just read clears the pending flags and changes nothing else.

One interrupt line is raised whenever a flag is set while its enable is set.

The register port is a plain write strobe with an address and write data, plus a read-data output that follows the address combinationally. It has no handshake and never stalls. A write takes effect at the clock edge on which the strobe is high. The event inputs are level samples, and each clock that a selected line is high counts once. They carry no flow control.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all four locations read 0 and the interrupt is low.
- R2: Address 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. Any 32-bit value written to a counter reads back unchanged.
- R3: Control bit 0 is the only enable. While it is 0 no counter changes except through writes and reset bits.
- R4: Event counter 0 takes its code from control bits 27:20 and event counter 1 from bits 19:12. On each enabled clock where input line `evt_i[code]` is high, the counter adds 1. Code 0x20, or any code at or above the number of inputs, never counts.
- R5: With control bit 3 at 0, the cycle counter adds 1 on every enabled clock.
- R6: With control bit 3 at 1, the cycle counter adds 1 once every 64 enabled clocks. The divider restarts when the cycle counter is reset, so the first step comes 64 clocks after the reset write.
- R7: Writing 1 to control bit 1 zeroes both event counters. Writing 1 to bit 2 zeroes the cycle counter. Both bits always read 0.
- R8: Overflow flags are at bit 8 (event counter 0), bit 9 (event counter 1) and bit 10 (cycle counter). A flag is set when an increment takes its counter from 0xFFFFFFFF to 0. It stays set until cleared.
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it alone. Writing back a control value that was just read clears the set flags and leaves every other field as it was.
- R10: The interrupt is high exactly when some flag is set while its enable is set. The enables are bit 4 (event counter 0), bit 5 (event counter 1) and bit 6 (cycle counter).
- R11: A write to a counter in the same clock as an increment stores the written value and sets no flag, even if the old value was 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 2 | Location to read or write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed location |
| evt_i | input | NUM_EVT | Event pulse lines, one count per clock high |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
The event selectors are driven with a small set of patterns:
- only the line one counter selects, which shows that the two selectors are independent;
- both selected lines together;
- every line high while one counter holds the silent code or an out-of-range code, which shows that those codes reach no input;
- the same line feeding both counters.

The cycle counter is run at full rate, then at the divided rate, and sampled at 63 and at 64 clocks so that the divider phase is pinned down. The wrap tests step each counter through 0xFFFFFFFF one increment at a time. They also land a counter write on an increment at that value, which separates an overflow from a load.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CODE_W     = 8;
  localparam int REG_W      = 32;
  localparam int NUM_CNT    = 3;
  localparam int NUM_FLAG   = 3;

  localparam int B_EN       = 0;
  localparam int B_RST_EV   = 1;
  localparam int B_RST_CYC  = 2;
  localparam int B_DIV      = 3;
  localparam int B_IEN_LO   = 4;
  localparam int B_OVF_LO   = 8;
  localparam int B_CODE1_LO = 12;
  localparam int B_CODE0_LO = 20;

  localparam logic [CODE_W-1:0] SILENT_CODE = 8'h20;

  typedef enum logic [1:0] {
    LOC_CTRL = 2'd0,
    LOC_CYC  = 2'd1,
    LOC_EV0  = 2'd2,
    LOC_EV1  = 2'd3
  } loc_e;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  // load beats clear beats increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = inc_i && !load_i && !clr_i && (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 32
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic               hit_o
);
  logic line;

  always_comb begin
    line = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (code_i == CODE_W'(i)) line = evt_i[i];
    end
  end

  assign hit_o = line && (code_i != SILENT_CODE);
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int RATIO = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ph_q <= '0;
    else if (restart_i)  ph_q <= '0;
    else if (run_i)      ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
  end

  assign tick_o = run_i && !restart_i && (ph_q == LAST);
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_EVT   = 32,
  parameter int DIV_RATIO = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  logic                  en_q, div_q;
  logic [NUM_FLAG-1:0]   ien_q, ovf_q;
  logic [1:0][CODE_W-1:0] code_q;

  logic                  ctrl_wr, rst_ev, rst_cyc, div_tick;
  logic [1:0]            hit;
  logic [NUM_CNT-1:0]    load, clr, inc, wrap;
  logic [CNT_W-1:0]      cnt_val [NUM_CNT];
  logic [NUM_FLAG-1:0]   flag_set, flag_clr;
  logic                  unused_wbits;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == LOC_CTRL);
  assign rst_ev  = ctrl_wr && reg_wdata_i[B_RST_EV];
  assign rst_cyc = ctrl_wr && reg_wdata_i[B_RST_CYC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      div_q  <= 1'b0;
      ien_q  <= '0;
      code_q <= '0;
    end else if (ctrl_wr) begin
      en_q      <= reg_wdata_i[B_EN];
      div_q     <= reg_wdata_i[B_DIV];
      ien_q     <= reg_wdata_i[B_IEN_LO +: NUM_FLAG];
      code_q[0] <= reg_wdata_i[B_CODE0_LO +: CODE_W];
      code_q[1] <= reg_wdata_i[B_CODE1_LO +: CODE_W];
    end
  end

  // flag order: event 0, event 1, cycle; a new wrap wins over a clear
  assign flag_set = {wrap[0], wrap[2], wrap[1]};
  assign flag_clr = ctrl_wr ? reg_wdata_i[B_OVF_LO +: NUM_FLAG] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else         ovf_q <= (ovf_q & ~flag_clr) | flag_set;
  end

  for (genvar s = 0; s < 2; s++) begin : g_sel
    pmu_event_sel #(.NUM_EVT(NUM_EVT)) u_sel (
      .evt_i  (evt_i),
      .code_i (code_q[s]),
      .hit_o  (hit[s])
    );
  end

  pmu_prescaler #(.RATIO(DIV_RATIO)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (en_q && div_q),
    .restart_i (rst_cyc),
    .tick_o    (div_tick)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign load[i] = reg_wr_i && (reg_addr_i == 2'(i + 1));
    if (i == 0) begin : g_cyc
      assign clr[i] = rst_cyc;
      assign inc[i] = en_q && (!div_q || div_tick);
    end else begin : g_ev
      assign clr[i] = rst_ev;
      assign inc[i] = en_q && hit[i-1];
    end
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load[i]),
      .load_val_i (reg_wdata_i[CNT_W-1:0]),
      .clr_i      (clr[i]),
      .inc_i      (inc[i]),
      .cnt_o      (cnt_val[i]),
      .wrap_o     (wrap[i])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      LOC_CTRL: begin
        reg_rdata_o[B_EN]                    = en_q;
        reg_rdata_o[B_DIV]                   = div_q;
        reg_rdata_o[B_IEN_LO +: NUM_FLAG]    = ien_q;
        reg_rdata_o[B_OVF_LO +: NUM_FLAG]    = ovf_q;
        reg_rdata_o[B_CODE0_LO +: CODE_W]    = code_q[0];
        reg_rdata_o[B_CODE1_LO +: CODE_W]    = code_q[1];
      end
      LOC_CYC: reg_rdata_o = REG_W'(cnt_val[0]);
      LOC_EV0: reg_rdata_o = REG_W'(cnt_val[1]);
      default: reg_rdata_o = REG_W'(cnt_val[2]);
    endcase
  end

  assign irq_o = |(ovf_q & ien_q);

  assign unused_wbits = ^{reg_wdata_i[31:28], reg_wdata_i[11], reg_wdata_i[7]};
endmodule

// File: rtl/pmu_checks.sv
module pmu_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr,
  input logic [1:0]   addr,
  input logic [31:0]  wdata,
  input logic         irq,
  input logic         en,
  input logic [7:0]   code0,
  input logic [2:0]   ovf,
  input logic [2:0]   ien,
  input logic [W-1:0] c_cyc,
  input logic [W-1:0] c_ev0,
  input logic [W-1:0] c_ev1
);
  p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr) |=> ($stable(c_cyc) && $stable(c_ev0) && $stable(c_ev1)));

  p_silent_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && code0 == 8'h20 && !wr) |=> $stable(c_ev0));

  p_ev_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0 && wdata[1]) |=> (c_ev0 == '0 && c_ev1 == '0));

  p_wrap_ev0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf[0]) |-> ($past(c_ev0) == '1 && c_ev0 == '0));

  p_wrap_cyc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf[2]) |-> ($past(c_cyc) == '1 && c_cyc == '0));

  p_sticky_ev1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[1] && !(wr && addr == 2'd0 && wdata[9])) |=> ovf[1]);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf == 3'b000 || ien == 3'b000) |-> !irq);

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd2) |=> (c_ev0 == $past(wdata[W-1:0])));
endmodule

bind perf_mon_unit pmu_checks #(.W(CNT_W)) u_chk (
  .clk   (clk_i),
  .rst_n (rst_ni),
  .wr    (reg_wr_i),
  .addr  (reg_addr_i),
  .wdata (reg_wdata_i),
  .irq   (irq_o),
  .en    (en_q),
  .code0 (code_q[0]),
  .ovf   (ovf_q),
  .ien   (ien_q),
  .c_cyc (cnt_val[0]),
  .c_ev0 (cnt_val[1]),
  .c_ev1 (cnt_val[2])
);

// File: tb/sim_perf_mon_unit.sv
`timescale 1ns/1ps
module sim_perf_mon_unit;
  localparam int NEV = 32;
  localparam logic [31:0] EN = 32'h1, RSTE = 32'h2, RSTC = 32'h4, DIV = 32'h8;
  localparam logic [31:0] IE0 = 32'h10, IEC = 32'h40;
  localparam logic [31:0] F0 = 32'h100, FC = 32'h400;

  typedef struct packed {
    logic [7:0]  c0;
    logic [7:0]  c1;
    logic [31:0] ev;
    logic [7:0]  n;
    logic [31:0] e0;
    logic [31:0] e1;
  } vec_t;

  localparam vec_t TABLE [5] = '{
    '{8'h07, 8'h06, 32'h0000_0080, 8'd5, 32'd5, 32'd0},
    '{8'h07, 8'h06, 32'h0000_00C0, 8'd3, 32'd3, 32'd3},
    '{8'h20, 8'h00, 32'hFFFF_FFFF, 8'd4, 32'd0, 32'd4},
    '{8'h40, 8'h1F, 32'hFFFF_FFFF, 8'd2, 32'd0, 32'd2},
    '{8'h00, 8'h00, 32'h0000_0001, 8'd6, 32'd6, 32'd6}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NEV-1:0] evt = '0;
  logic irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  perf_mon_unit #(.CNT_W(32), .NUM_EVT(NEV), .DIV_RATIO(64)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic pulse(input logic [NEV-1:0] v, input int n);
    evt = v;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, cv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), rd);
      check("R1", "reset value", rd, 32'h0);
    end
    check("R1", "reset irq", {31'b0, irq}, 32'h0);

    // R2 address map and full-range writes
    reg_write(2'd1, 32'hA5A5_A5A5);
    reg_write(2'd2, 32'h5A5A_5A5A);
    reg_write(2'd3, 32'hFFFF_FFFF);
    reg_read(2'd1, rd); check("R2", "cycle rw", rd, 32'hA5A5_A5A5);
    reg_read(2'd2, rd); check("R2", "ev0 rw", rd, 32'h5A5A_5A5A);
    reg_read(2'd3, rd); check("R2", "ev1 rw", rd, 32'hFFFF_FFFF);
    reg_write(2'd3, 32'h0);
    reg_read(2'd3, rd); check("R2", "ev1 zero", rd, 32'h0);

    // R7 shared resets, R3 nothing counts while disabled
    reg_write(2'd2, 32'd123);
    reg_write(2'd3, 32'd456);
    reg_write(2'd1, 32'd77);
    reg_write(2'd0, RSTE | (32'h07 << 20));
    reg_read(2'd2, rd); check("R7", "ev0 reset", rd, 32'h0);
    reg_read(2'd3, rd); check("R7", "ev1 reset", rd, 32'h0);
    reg_read(2'd1, rd); check("R7", "cycle untouched", rd, 32'd77);
    reg_read(2'd0, rd); check("R7", "reset bits read 0", rd & 32'h6, 32'h0);
    pulse(32'h80, 5);
    repeat (5) @(negedge clk);
    reg_read(2'd2, rd); check("R3", "ev0 frozen", rd, 32'h0);
    reg_read(2'd1, rd); check("R3", "cycle frozen", rd, 32'd77);
    reg_write(2'd0, RSTC);
    reg_read(2'd1, rd); check("R7", "cycle reset", rd, 32'h0);

    // R4 table of selector patterns
    for (int k = 0; k < 5; k++) begin
      reg_write(2'd0, EN | RSTE | (32'(TABLE[k].c0) << 20) | (32'(TABLE[k].c1) << 12));
      pulse(TABLE[k].ev, int'(TABLE[k].n));
      reg_read(2'd2, rd); check("R4", $sformatf("vec%0d ev0", k), rd, TABLE[k].e0);
      reg_read(2'd3, rd); check("R4", $sformatf("vec%0d ev1", k), rd, TABLE[k].e1);
    end

    // R5 full-rate cycle counting
    reg_write(2'd0, EN | RSTC);
    reg_read(2'd1, rd); check("R5", "after reset", rd, 32'h0);
    repeat (10) @(negedge clk);
    reg_read(2'd1, rd); check("R5", "10 clocks", rd, 32'd10);

    // R6 divided rate
    reg_write(2'd0, EN | DIV | RSTC);
    repeat (63) @(negedge clk);
    reg_read(2'd1, rd); check("R6", "63 clocks", rd, 32'd0);
    @(negedge clk);
    reg_read(2'd1, rd); check("R6", "64 clocks", rd, 32'd1);
    repeat (64) @(negedge clk);
    reg_read(2'd1, rd); check("R6", "128 clocks", rd, 32'd2);

    // R8 / R10 event counter 0 wrap
    reg_write(2'd0, EN | IE0 | (32'h07 << 20));
    reg_write(2'd2, 32'hFFFF_FFFE);
    pulse(32'h80, 1);
    reg_read(2'd2, rd); check("R8", "ev0 at max", rd, 32'hFFFF_FFFF);
    reg_read(2'd0, rd); check("R8", "no flag yet", rd & F0, 32'h0);
    check("R10", "irq low before wrap", {31'b0, irq}, 32'h0);
    pulse(32'h80, 1);
    reg_read(2'd2, rd); check("R8", "ev0 wrapped", rd, 32'h0);
    reg_read(2'd0, rd); check("R8", "ev0 flag", rd & F0, F0);
    check("R10", "irq on wrap", {31'b0, irq}, 32'h1);
    reg_write(2'd0, EN | (32'h07 << 20));
    reg_read(2'd0, rd); check("R9", "flag kept on write 0", rd & F0, F0);
    check("R10", "irq masked", {31'b0, irq}, 32'h0);
    reg_read(2'd0, cv);
    reg_write(2'd0, cv);
    reg_read(2'd0, rd); check("R9", "write-back clears flag only", rd, cv & ~F0);

    // R11 counter write beats increment
    evt = 32'h80;
    reg_write(2'd2, 32'h55);
    evt = '0;
    reg_read(2'd2, rd); check("R11", "load beats inc", rd, 32'h55);
    reg_write(2'd2, 32'hFFFF_FFFF);
    evt = 32'h80;
    reg_write(2'd2, 32'h0);
    evt = '0;
    reg_read(2'd2, rd); check("R11", "load at max", rd, 32'h0);
    reg_read(2'd0, rd); check("R11", "no flag from load", rd & F0, 32'h0);

    // R8 / R10 cycle counter wrap
    reg_write(2'd0, EN | IEC);
    reg_write(2'd1, 32'hFFFF_FFFD);
    repeat (2) @(negedge clk);
    reg_read(2'd1, rd); check("R8", "cycle at max", rd, 32'hFFFF_FFFF);
    reg_read(2'd0, rd); check("R8", "cycle no flag", rd & FC, 32'h0);
    @(negedge clk);
    reg_read(2'd1, rd); check("R8", "cycle wrapped", rd, 32'h0);
    reg_read(2'd0, rd); check("R8", "cycle flag", rd & FC, FC);
    check("R10", "irq cycle", {31'b0, irq}, 32'h1);
    repeat (4) @(negedge clk);
    reg_read(2'd0, rd); check("R8", "cycle flag sticky", rd & FC, FC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule